// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps a running time of day as a seconds count and a sub-seconds count. The sub-seconds count moves forward on every reference clock edge. In coarse mode it grows by a fixed programmed step on each edge. In fine mode it grows by that step only on the edges where a phase accumulator overflows. The accumulator adds a programmable addend each cycle, so the addend sets the effective rate and gives a frequency trim. A configuration bit picks where sub-seconds wrap into the seconds count. One setting is a decimal nanosecond limit. The other is a binary limit of half the 32-bit range.

Software changes the time through a command channel with a valid/ready handshake. A command either loads an absolute time or adds or subtracts a signed offset. The channel accepts a command when `cmd_valid` and `cmd_ready` are both high on a clock edge. On the next cycle `cmd_ready` is low while the held command is applied. The source must keep its command stable while valid is high and ready is low. A command offered during that cycle is not taken. An offset is applied on top of the step of the same cycle, so no increment is lost. Other logic reads the live time directly. A snapshot strobe captures seconds and sub-seconds together, so a later two-part read returns one coherent time.

Top module: `ptp_time_counter`

## Requirements
- R1: While reset is asserted, time_sec, time_sub, snap_sec and snap_sub are all zero and cmd_ready is 1.
- R2: In coarse mode (cfg_fine = 0), time_sub increases by cfg_incr on every clock edge when no command is being applied.
- R3: In fine mode (cfg_fine = 1), a 32-bit accumulator cleared while coarse mode is selected adds cfg_addend on every edge. time_sub advances by cfg_incr only on the edges where that addition carries out of 32 bits. With addend 0x80000000 this gives one step every second edge.
- R4: With cfg_decimal = 1, a sub-seconds result above 999,999,999 wraps by subtracting 1,000,000,000, and time_sec increments by one.
- R5: With cfg_decimal = 0, a sub-seconds result above 0x7FFFFFFF wraps by subtracting 0x80000000, and time_sec increments by one.
- R6: A load command (cmd_kind = 0) accepted on edge E replaces the time with cmd_sec and cmd_sub on edge E+1. That edge's step is not added.
- R7: An add-offset command (cmd_kind = 1, cmd_neg = 0) accepted on edge E sets the time on edge E+1 to the stepped time plus the offset. A sub-seconds carry past the active limit increments seconds. The offset sub-seconds value must not exceed the active limit.
- R8: A subtract-offset command (cmd_kind = 1, cmd_neg = 1) sets the time on edge E+1 to the stepped time minus the offset. A sub-seconds borrow adds the active span back to sub-seconds and takes one from seconds.
- R9: cmd_ready is 0 for exactly the cycle after an acceptance. A command held valid through that cycle is applied only once.
- R10: On an edge where snap_req is 1, snap_sec and snap_sub capture the time of day held before that edge. They keep those values until the next snap_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_decimal | input | 1 | 1: decimal nanosecond wrap, 0: binary wrap |
| cfg_fine | input | 1 | 1: accumulator-gated stepping, 0: step every edge |
| cfg_incr | input | 8 | Sub-seconds step size |
| cfg_addend | input | 32 | Fine-mode accumulator addend |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_kind | input | 1 | 0: load absolute time, 1: apply offset |
| cmd_neg | input | 1 | Offset sign, 1 subtracts |
| cmd_sec | input | 32 | Command seconds value |
| cmd_sub | input | 32 | Command sub-seconds value |
| snap_req | input | 1 | Capture the current time into the snapshot |
| snap_sec | output | 32 | Captured seconds |
| snap_sub | output | 32 | Captured sub-seconds |
| time_sec | output | 32 | Live seconds |
| time_sub | output | 32 | Live sub-seconds |

## Verification
Most internal faults show on time_sub within one or two edges. A wrong wrap limit or a missing carry puts sub-seconds out of range, or leaves seconds unchanged, on the first edge that crosses the limit. A bad accumulator changes how many steps land in a fine-mode window, and that shows after a few tens of edges. A mishandled command shows as a doubled offset, a dropped step or a borrow error in the cycle after acceptance. A faulty snapshot register shows as a mismatch with the live time read just before the strobe.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  typedef enum logic {
    CMD_LOAD  = 1'b0,
    CMD_SHIFT = 1'b1
  } cmd_kind_e;

  localparam longint unsigned DEC_WRAP_LIMIT = 64'd999_999_999;
  localparam longint unsigned BIN_WRAP_LIMIT = 64'h7FFF_FFFF;

endpackage

// File: rtl/ptp_tc_stepgen.sv
module ptp_tc_stepgen #(
  parameter int INC_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fine,
  input  logic [INC_W-1:0] incr,
  input  logic [ACC_W-1:0] addend,
  output logic [INC_W-1:0] step
);
  localparam logic [ACC_W-1:0] HALF_SCALE = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] phase_q;
  logic [ACC_W:0]   phase_sum;
  logic             carry_hit;

  always_comb begin
    phase_sum = {1'b0, phase_q} + {1'b0, addend};
    carry_hit = fine && phase_sum[ACC_W];
    step      = (!fine || carry_hit) ? incr : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !fine) phase_q <= '0;
    else                 phase_q <= phase_sum[ACC_W-1:0];
  end

  // An addend of at most half scale can never overflow on two edges in a row
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (fine && $past(fine) && $stable(addend) && addend <= HALF_SCALE && $past(carry_hit))
      |-> !carry_hit) else $error("back-to-back carry"); // R3

endmodule

// File: rtl/ptp_tc_wrap.sv
module ptp_tc_wrap #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32
) (
  input  logic [SEC_W-1:0] base_sec,
  input  logic [SUB_W-1:0] base_sub,
  input  logic [SEC_W-1:0] delta_sec,
  input  logic [SUB_W-1:0] delta_sub,
  input  logic             minus,
  input  logic [SUB_W-1:0] limit,
  output logic [SEC_W-1:0] res_sec,
  output logic [SUB_W-1:0] res_sub
);
  localparam int XW = SUB_W + 1;

  logic [XW-1:0] span;
  logic [XW-1:0] sum_x;
  logic [XW-1:0] dif_x;
  logic          over;
  logic          under;

  always_comb begin
    span  = {1'b0, limit} + XW'(1);
    sum_x = {1'b0, base_sub} + {1'b0, delta_sub};
    over  = sum_x > {1'b0, limit};
    under = base_sub < delta_sub;
    dif_x = {1'b0, base_sub} - {1'b0, delta_sub} + (under ? span : '0);
    if (minus) begin
      res_sub = dif_x[SUB_W-1:0];
      res_sec = base_sec - delta_sec - SEC_W'(under);
    end else begin
      res_sub = over ? SUB_W'(sum_x - span) : sum_x[SUB_W-1:0];
      res_sec = base_sec + delta_sec + SEC_W'(over);
    end
  end

endmodule

// File: rtl/ptp_tc_cmd.sv
module ptp_tc_cmd
  import ptp_tc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_kind,
  input  logic             cmd_neg,
  input  logic [SEC_W-1:0] cmd_sec,
  input  logic [SUB_W-1:0] cmd_sub,
  output logic             do_load,
  output logic             do_shift,
  output logic             hold_neg,
  output logic [SEC_W-1:0] hold_sec,
  output logic [SUB_W-1:0] hold_sub
);
  logic      pending_q;
  cmd_kind_e kind_q;
  logic      accept;

  assign cmd_ready = !pending_q;
  assign accept    = cmd_valid && cmd_ready;
  assign do_load   = pending_q && (kind_q == CMD_LOAD);
  assign do_shift  = pending_q && (kind_q == CMD_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      kind_q    <= CMD_LOAD;
      hold_neg  <= 1'b0;
      hold_sec  <= '0;
      hold_sub  <= '0;
    end else begin
      pending_q <= accept;
      if (accept) begin
        kind_q   <= cmd_kind_e'(cmd_kind);
        hold_neg <= cmd_neg;
        hold_sec <= cmd_sec;
        hold_sub <= cmd_sub;
      end
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready) else $error("ready stayed high"); // R9
  AST_APPLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (do_load || do_shift) |=> !(do_load || do_shift)) else $error("command applied twice"); // R9

endmodule

// File: rtl/ptp_tc_snap.sv
module ptp_tc_snap #(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_req,
  input  logic [SEC_W-1:0] live_sec,
  input  logic [SUB_W-1:0] live_sub,
  output logic [SEC_W-1:0] snap_sec,
  output logic [SUB_W-1:0] snap_sub
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_sec <= '0;
      snap_sub <= '0;
    end else if (snap_req) begin
      snap_sec <= live_sec;
      snap_sub <= live_sub;
    end
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> ($stable(snap_sec) && $stable(snap_sub))) else $error("snapshot moved"); // R10

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int SUB_W = 32,
  parameter int INC_W = 8,
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_decimal,
  input  logic             cfg_fine,
  input  logic [INC_W-1:0] cfg_incr,
  input  logic [ACC_W-1:0] cfg_addend,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_kind,
  input  logic             cmd_neg,
  input  logic [SEC_W-1:0] cmd_sec,
  input  logic [SUB_W-1:0] cmd_sub,
  input  logic             snap_req,
  output logic [SEC_W-1:0] snap_sec,
  output logic [SUB_W-1:0] snap_sub,
  output logic [SEC_W-1:0] time_sec,
  output logic [SUB_W-1:0] time_sub
);
  localparam logic [SUB_W-1:0] LIM_DEC = SUB_W'(DEC_WRAP_LIMIT);
  localparam logic [SUB_W-1:0] LIM_BIN = SUB_W'(BIN_WRAP_LIMIT);

  logic [SUB_W-1:0] limit;
  logic [INC_W-1:0] step;
  logic [SEC_W-1:0] inc_sec, ofs_sec, nxt_sec, hold_sec;
  logic [SUB_W-1:0] inc_sub, ofs_sub, nxt_sub, hold_sub;
  logic             do_load, do_shift, hold_neg;

  assign limit = cfg_decimal ? LIM_DEC : LIM_BIN;

  ptp_tc_stepgen #(.INC_W(INC_W), .ACC_W(ACC_W)) u_step (
    .clk(clk), .rst_n(rst_n), .fine(cfg_fine),
    .incr(cfg_incr), .addend(cfg_addend), .step(step)
  );

  ptp_tc_cmd #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_neg(cmd_neg), .cmd_sec(cmd_sec), .cmd_sub(cmd_sub),
    .do_load(do_load), .do_shift(do_shift),
    .hold_neg(hold_neg), .hold_sec(hold_sec), .hold_sub(hold_sub)
  );

  // step of this edge
  ptp_tc_wrap #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_inc (
    .base_sec(time_sec), .base_sub(time_sub),
    .delta_sec('0), .delta_sub(SUB_W'(step)),
    .minus(1'b0), .limit(limit),
    .res_sec(inc_sec), .res_sub(inc_sub)
  );

  // signed offset on top of the stepped value
  ptp_tc_wrap #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_ofs (
    .base_sec(inc_sec), .base_sub(inc_sub),
    .delta_sec(hold_sec), .delta_sub(hold_sub),
    .minus(hold_neg), .limit(limit),
    .res_sec(ofs_sec), .res_sub(ofs_sub)
  );

  always_comb begin
    if (do_load) begin
      nxt_sec = hold_sec;
      nxt_sub = hold_sub;
    end else if (do_shift) begin
      nxt_sec = ofs_sec;
      nxt_sub = ofs_sub;
    end else begin
      nxt_sec = inc_sec;
      nxt_sub = inc_sub;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_sec <= '0;
      time_sub <= '0;
    end else begin
      time_sec <= nxt_sec;
      time_sub <= nxt_sub;
    end
  end

  ptp_tc_snap #(.SEC_W(SEC_W), .SUB_W(SUB_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .snap_req(snap_req),
    .live_sec(time_sec), .live_sub(time_sub),
    .snap_sec(snap_sec), .snap_sub(snap_sub)
  );

  AST_SUB_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_ready) && $stable(cfg_decimal) && $past(time_sub) <= limit)
      |-> time_sub <= limit) else $error("sub-seconds out of range"); // R4
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_ready) |-> (time_sec == $past(time_sec) ||
                          time_sec == $past(time_sec) + SEC_W'(1)))
    else $error("seconds jumped"); // R5

endmodule

// File: tb/tb_ptp_time_counter.sv
module tb_ptp_time_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_decimal, cfg_fine;
  logic [7:0]  cfg_incr;
  logic [31:0] cfg_addend;
  logic        cmd_valid, cmd_kind, cmd_neg;
  logic        cmd_ready;
  logic [31:0] cmd_sec, cmd_sub;
  logic        snap_req;
  logic [31:0] snap_sec, snap_sub, time_sec, time_sub;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;
  longint e_sec, e_sub;

  localparam longint DEC = 64'd999_999_999;
  localparam longint BIN = 64'h7FFF_FFFF;

  always #5 clk = ~clk;

  ptp_time_counter dut (
    .clk(clk), .rst_n(rst_n), .cfg_decimal(cfg_decimal), .cfg_fine(cfg_fine),
    .cfg_incr(cfg_incr), .cfg_addend(cfg_addend), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_neg(cmd_neg),
    .cmd_sec(cmd_sec), .cmd_sub(cmd_sub), .snap_req(snap_req),
    .snap_sec(snap_sec), .snap_sub(snap_sub), .time_sec(time_sec), .time_sub(time_sub)
  );

  function automatic longint lim();
    return cfg_decimal ? DEC : BIN;
  endfunction

  function automatic void roll(longint d);
    e_sub += d;
    while (e_sub > lim()) begin e_sub -= lim() + 1; e_sec++; end
    while (e_sub < 0)     begin e_sub += lim() + 1; e_sec--; end
  endfunction

  task automatic check_time(string tag, logic [31:0] as, logic [31:0] au);
    total++;
    if (as !== e_sec[31:0] || au !== e_sub[31:0]) begin
      bad++;
      $display("FAIL %s: got %0d.%0d expected %0d.%0d", tag, as, au, e_sec[31:0], e_sub[31:0]);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic take();
    e_sec = longint'(time_sec);
    e_sub = longint'(time_sub);
  endtask

  // offer a command at a negedge; optionally keep it valid through the busy cycle
  task automatic send(logic kind, logic neg, logic [31:0] s, logic [31:0] u, bit hold2);
    cmd_valid = 1'b1; cmd_kind = kind; cmd_neg = neg; cmd_sec = s; cmd_sub = u;
    tick(1);
    check_bit("R9 ready low after accept", cmd_ready, 1'b0);
    if (!hold2) cmd_valid = 1'b0;
    tick(1);
    cmd_valid = 1'b0;
  endtask

  task automatic load(longint s, longint u);
    send(1'b0, 1'b0, s[31:0], u[31:0], 1'b0);
    e_sec = s; e_sub = u;
    check_time("R6 load", time_sec, time_sub);
  endtask

  task automatic shift(logic neg, longint s, longint u, bit hold2, string tag);
    take();
    send(1'b1, neg, s[31:0], u[31:0], hold2);
    roll(2 * longint'(cfg_incr));
    if (neg) begin e_sec -= s; roll(-u); end
    else     begin e_sec += s; roll(u);  end
    check_time(tag, time_sec, time_sub);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int incs[5] = '{1, 2, 7, 128, 255};
    longint acc;
    rst_n = 1'b0; cfg_decimal = 1'b1; cfg_fine = 1'b0; cfg_incr = 8'd7;
    cfg_addend = 32'h8000_0000; cmd_valid = 1'b0; cmd_kind = 1'b0; cmd_neg = 1'b0;
    cmd_sec = '0; cmd_sub = '0; snap_req = 1'b0;
    tick(3);
    // R1 reset state
    e_sec = 0; e_sub = 0;
    check_time("R1 time", time_sec, time_sub);
    check_time("R1 snap", snap_sec, snap_sub);
    check_bit("R1 ready", cmd_ready, 1'b1);
    rst_n = 1'b1;
    tick(1);

    // R2 coarse stepping
    load(5, 100);
    tick(10); roll(70);
    check_time("R2 coarse", time_sec, time_sub);

    // R4 decimal wrap
    load(9, 999_999_990);
    tick(3); roll(21);
    check_time("R4 decimal wrap", time_sec, time_sub);

    // R5 binary wrap
    cfg_decimal = 1'b0;
    load(0, 64'h7FFF_FFFC);
    tick(1); roll(7);
    check_time("R5 binary wrap", time_sec, time_sub);

    // sweep of step sizes and start points around both limits
    for (int m = 0; m < 2; m++) begin
      cfg_decimal = m[0];
      for (int k = 0; k < 5; k++) begin
        cfg_incr = incs[k][7:0];
        for (int b = 0; b < 4; b++) begin
          load(3, lim() - longint'(b * incs[k]));
          tick(6); roll(6 * longint'(incs[k]));
          check_time(m == 1 ? "R4 sweep" : "R5 sweep", time_sec, time_sub);
        end
      end
    end

    // R7 / R8 offsets, decimal mode
    cfg_decimal = 1'b1; cfg_incr = 8'd1;
    load(100, 999_999_000);
    shift(1'b0, 2, 5000, 1'b0, "R7 add with carry");
    shift(1'b0, 0, 999_999_999, 1'b0, "R7 add max sub");
    load(50, 10);
    shift(1'b1, 3, 500, 1'b0, "R8 subtract with borrow");
    shift(1'b1, 1, 0, 1'b0, "R8 subtract seconds only");
    cfg_decimal = 1'b0;
    load(7, 3);
    shift(1'b1, 0, 64'h7FFF_FFFF, 1'b0, "R8 binary borrow");

    // R9 command held through busy cycle is applied once
    cfg_decimal = 1'b1;
    load(20, 0);
    shift(1'b0, 1, 1000, 1'b1, "R9 held command once");
    check_bit("R9 ready restored", cmd_ready, 1'b1);

    // R3 fine mode
    cfg_incr = 8'd10;
    load(0, 0);
    cfg_fine = 1'b1; acc = 0;
    take();
    begin
      longint adds[4] = '{64'h8000_0000, 64'h4000_0000, 64'hFFFF_FFFF, 64'h1234_5678};
      int     lens[4] = '{20, 13, 9, 50};
      for (int i = 0; i < 4; i++) begin
        longint n;
        cfg_addend = adds[i][31:0];
        tick(lens[i]);
        acc = acc + longint'(lens[i]) * adds[i];
        n   = acc >>> 32;
        acc = acc & 64'hFFFF_FFFF;
        roll(n * 10);
        check_time("R3 fine rate", time_sec, time_sub);
      end
    end
    cfg_fine = 1'b0;
    tick(1);

    // R10 snapshot
    take();
    snap_req = 1'b1;
    tick(1);
    snap_req = 1'b0;
    check_time("R10 snapshot capture", snap_sec, snap_sub);
    tick(5);
    check_time("R10 snapshot held", snap_sec, snap_sub);
    total++;
    if (time_sub == snap_sub) begin
      bad++;
      $display("FAIL R10 live time: got %0d expected change from %0d", time_sub, snap_sub);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule